// File: doc/BRIEF.md
# Branch Target and Next-PC Unit

This block resolves control flow for one instruction of a 32-bit RISC core. Each cycle in which the strobe is high, it takes the current program counter, the six-bit opcode, the 26-bit immediate field (bits 25..0 of the instruction word) and the two register operand values. In the next cycle it presents the following program counter, a taken flag, a link-register write (enable and value), a return-form tag for register jumps, and an exception request with a cause code. Instruction fetch and exception vectoring are handled elsewhere. A call always targets register 29, so the link port carries only an enable and a value.

The block is built around a three-state machine. ST_IDLE means no result is pending. ST_FLOW means a normal result is on the outputs, whether sequential, jump or branch. ST_TRAP means an exception request is on the outputs. From any state, a strobe with an exception-raising instruction moves to ST_TRAP. A strobe with any other instruction moves to ST_FLOW, and a cycle without a strobe returns to ST_IDLE. The next-PC value is held while the machine is idle.

The 16-bit immediate is bits 15..0 of the immediate field, and the register-source index is bits 25..21. Conditional branches compare operand A against operand B.

Top module: `nxpc_unit`

## Requirements
- R1: While reset is high and after it is released, every output is zero until the first strobe.
- R2: Results appear in the cycle after the strobe. In a cycle after a cycle with no strobe, taken, link enable and exception request are low, and next_pc keeps its last value.
- R3: Opcodes 0x38 (jump) and 0x3E (call) give next_pc = PC + sign-extend(imm26 << 2) from 28 bits, with taken high.
- R4: Opcodes 0x11 (equal), 0x17 (not equal), 0x12 (signed greater), 0x13 (signed greater-or-equal), 0x15 (unsigned greater) and 0x14 (unsigned greater-or-equal) compare A with B. When the condition holds, next_pc = PC + sign-extend(imm16)*4 and taken is high. Otherwise next_pc = PC+4 and taken is low.
- R5: The call opcodes 0x3E and 0x36 raise the link enable with value PC+4. No other opcode raises it.
- R6: Opcode 0x30 (register jump) and 0x36 (register call) give next_pc = A with bits 1..0 cleared, with taken high. For 0x30, the return tag is 1, 2 or 3 when the source index is 29, 30 or 31 respectively, and 0 otherwise. For 0x36 the tag is 0.
- R7: Opcode 0x2B raises an exception with next_pc = PC. A code of 7 in bits 4..0 gives cause 2 (breakpoint). A code of 2 gives cause 1 (system call). Any other code gives cause 4 (illegal).
- R8: Opcodes 0x23 and 0x31 with B = 0 raise an exception with cause 3 and next_pc = PC. With B non-zero they give PC+4 and no exception.
- R9: Every other opcode gives next_pc = PC+4, with taken, link enable and exception request low.
- R10: PC input bits 1..0 are ignored, and next_pc bits 1..0 are always zero.
- R11: An exception request is never accompanied by taken or the link enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Instruction strobe |
| pc_i | input | 32 | Current program counter |
| opcode_i | input | 6 | Instruction opcode |
| imm_i | input | 26 | Instruction bits 25..0 |
| opa_i | input | 32 | First source operand |
| opb_i | input | 32 | Second source operand |
| next_pc_o | output | 32 | Following program counter |
| taken_o | output | 1 | Jump, call or taken branch |
| link_we_o | output | 1 | Write PC+4 to register 29 |
| link_val_o | output | 32 | Link value |
| ret_kind_o | output | 2 | Return tag of a register jump |
| exc_req_o | output | 1 | Exception request |
| exc_cause_o | output | 3 | Exception cause |

## Verification
A state register stuck in ST_TRAP or ST_FLOW would show taken or an exception request in the cycle after a strobe-free cycle. A wrong transition would give an exception on a sequential instruction, visible one cycle after the strobe. A wrong comparison or offset extension shows at next_pc in that same cycle. The bench therefore places signed and unsigned operands that disagree side by side, and uses negative offsets that cross zero. Because results are issued back to back, a stale held value would appear as a mismatch on the very next vector.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;

    typedef enum logic [1:0] {ST_IDLE, ST_FLOW, ST_TRAP} state_e;

    typedef enum logic [2:0] {FK_SEQ, FK_JIMM, FK_COND, FK_JREG, FK_SCALL, FK_DIV} flow_e;

    typedef enum logic [2:0] {CC_EQ, CC_NE, CC_GTS, CC_GES, CC_GTU, CC_GEU} cc_e;

    typedef struct packed {
        flow_e flow;
        cc_e   cc;
        logic  link;
    } dec_t;

    localparam logic [5:0] OP_BEQ   = 6'h11;
    localparam logic [5:0] OP_BGTS  = 6'h12;
    localparam logic [5:0] OP_BGES  = 6'h13;
    localparam logic [5:0] OP_BGEU  = 6'h14;
    localparam logic [5:0] OP_BGTU  = 6'h15;
    localparam logic [5:0] OP_BNE   = 6'h17;
    localparam logic [5:0] OP_DIVU  = 6'h23;
    localparam logic [5:0] OP_SCALL = 6'h2B;
    localparam logic [5:0] OP_JREG  = 6'h30;
    localparam logic [5:0] OP_MODU  = 6'h31;
    localparam logic [5:0] OP_CREG  = 6'h36;
    localparam logic [5:0] OP_JIMM  = 6'h38;
    localparam logic [5:0] OP_CIMM  = 6'h3E;

    localparam logic [2:0] CAUSE_NONE  = 3'd0;
    localparam logic [2:0] CAUSE_SYS   = 3'd1;
    localparam logic [2:0] CAUSE_BRK   = 3'd2;
    localparam logic [2:0] CAUSE_DIVZ  = 3'd3;
    localparam logic [2:0] CAUSE_ILL   = 3'd4;

    localparam logic [4:0] CODE_SYS = 5'd2;
    localparam logic [4:0] CODE_BRK = 5'd7;

    localparam logic [4:0] IDX_RA = 5'd29;
    localparam logic [4:0] IDX_EA = 5'd30;
    localparam logic [4:0] IDX_BA = 5'd31;

endpackage

// File: rtl/nxpc_decode.sv
module nxpc_decode
    import nxpc_pkg::*;
(
    input  logic [5:0] opcode,
    output dec_t       dec
);
    always_comb begin
        dec.flow = FK_SEQ;
        dec.cc   = CC_EQ;
        dec.link = 1'b0;
        unique case (opcode)
            OP_BEQ:   begin dec.flow = FK_COND; dec.cc = CC_EQ;  end
            OP_BNE:   begin dec.flow = FK_COND; dec.cc = CC_NE;  end
            OP_BGTS:  begin dec.flow = FK_COND; dec.cc = CC_GTS; end
            OP_BGES:  begin dec.flow = FK_COND; dec.cc = CC_GES; end
            OP_BGTU:  begin dec.flow = FK_COND; dec.cc = CC_GTU; end
            OP_BGEU:  begin dec.flow = FK_COND; dec.cc = CC_GEU; end
            OP_JIMM:  dec.flow = FK_JIMM;
            OP_CIMM:  begin dec.flow = FK_JIMM; dec.link = 1'b1; end
            OP_JREG:  dec.flow = FK_JREG;
            OP_CREG:  begin dec.flow = FK_JREG; dec.link = 1'b1; end
            OP_SCALL: dec.flow = FK_SCALL;
            OP_DIVU,
            OP_MODU:  dec.flow = FK_DIV;
            default:  dec.flow = FK_SEQ;
        endcase
    end
endmodule

// File: rtl/nxpc_compare.sv
module nxpc_compare
    import nxpc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  cc_e             cc,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            hold
);
    logic eq, gts, gtu;

    assign eq  = (a == b);
    assign gts = ($signed(a) > $signed(b));
    assign gtu = (a > b);

    always_comb begin
        unique case (cc)
            CC_EQ:   hold = eq;
            CC_NE:   hold = !eq;
            CC_GTS:  hold = gts;
            CC_GES:  hold = gts || eq;
            CC_GTU:  hold = gtu;
            CC_GEU:  hold = gtu || eq;
            default: hold = 1'b0;
        endcase
    end
endmodule

// File: rtl/nxpc_target.sv
module nxpc_target #(
    parameter int XLEN    = 32,
    parameter int LONG_W  = 26,
    parameter int SHORT_W = 16
) (
    input  logic [XLEN-1:0]   pc,
    input  logic [LONG_W-1:0] imm,
    input  logic [XLEN-1:0]   opa,
    output logic [XLEN-1:0]   pc_al,
    output logic [XLEN-1:0]   seq_t,
    output logic [XLEN-1:0]   long_t,
    output logic [XLEN-1:0]   short_t,
    output logic [XLEN-1:0]   reg_t
);
    localparam int LONG_PAD  = XLEN - LONG_W - 2;
    localparam int SHORT_PAD = XLEN - SHORT_W - 2;

    logic [XLEN-1:0] long_off, short_off;

    assign pc_al     = {pc[XLEN-1:2], 2'b00};
    assign long_off  = {{LONG_PAD{imm[LONG_W-1]}}, imm, 2'b00};
    assign short_off = {{SHORT_PAD{imm[SHORT_W-1]}}, imm[SHORT_W-1:0], 2'b00};
    assign seq_t     = pc_al + XLEN'(4);
    assign long_t    = pc_al + long_off;
    assign short_t   = pc_al + short_off;
    assign reg_t     = {opa[XLEN-1:2], 2'b00};
endmodule

// File: rtl/nxpc_unit.sv
module nxpc_unit
    import nxpc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int IMM_W  = 26,
    parameter int SHORT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [5:0]       opcode_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [XLEN-1:0]  opa_i,
    input  logic [XLEN-1:0]  opb_i,
    output logic [XLEN-1:0]  next_pc_o,
    output logic             taken_o,
    output logic             link_we_o,
    output logic [XLEN-1:0]  link_val_o,
    output logic [1:0]       ret_kind_o,
    output logic             exc_req_o,
    output logic [2:0]       exc_cause_o
);
    localparam int SRC_LSB = IMM_W - 5;

    dec_t            dec;
    logic            hold;
    logic [XLEN-1:0] pc_al, seq_t, long_t, short_t, reg_t;

    nxpc_decode u_dec (.opcode(opcode_i), .dec(dec));

    nxpc_compare #(.XLEN(XLEN)) u_cmp (
        .cc(dec.cc), .a(opa_i), .b(opb_i), .hold(hold)
    );

    nxpc_target #(.XLEN(XLEN), .LONG_W(IMM_W), .SHORT_W(SHORT_W)) u_tgt (
        .pc(pc_i), .imm(imm_i), .opa(opa_i), .pc_al(pc_al), .seq_t(seq_t),
        .long_t(long_t), .short_t(short_t), .reg_t(reg_t)
    );

    // next-result selection
    logic [XLEN-1:0] d_npc;
    logic            d_taken, d_link, d_exc;
    logic [2:0]      d_cause;
    logic [1:0]      d_kind;
    logic [4:0]      src_idx;

    assign src_idx = imm_i[IMM_W-1:SRC_LSB];

    always_comb begin
        d_npc   = seq_t;
        d_taken = 1'b0;
        d_link  = 1'b0;
        d_exc   = 1'b0;
        d_cause = CAUSE_NONE;
        d_kind  = 2'd0;
        unique case (dec.flow)
            FK_SEQ: d_npc = seq_t;
            FK_JIMM: begin
                d_npc   = long_t;
                d_taken = 1'b1;
                d_link  = dec.link;
            end
            FK_COND: begin
                d_npc   = hold ? short_t : seq_t;
                d_taken = hold;
            end
            FK_JREG: begin
                d_npc   = reg_t;
                d_taken = 1'b1;
                d_link  = dec.link;
                if (!dec.link) begin
                    unique case (src_idx)
                        IDX_RA:  d_kind = 2'd1;
                        IDX_EA:  d_kind = 2'd2;
                        IDX_BA:  d_kind = 2'd3;
                        default: d_kind = 2'd0;
                    endcase
                end
            end
            FK_SCALL: begin
                d_npc = pc_al;
                d_exc = 1'b1;
                unique case (imm_i[4:0])
                    CODE_BRK: d_cause = CAUSE_BRK;
                    CODE_SYS: d_cause = CAUSE_SYS;
                    default:  d_cause = CAUSE_ILL;
                endcase
            end
            FK_DIV: begin
                if (opb_i == '0) begin
                    d_npc   = pc_al;
                    d_exc   = 1'b1;
                    d_cause = CAUSE_DIVZ;
                end
            end
            default: d_npc = seq_t;
        endcase
    end

    // state register
    state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else if (!valid_i) begin
            state_q <= ST_IDLE;
        end else if (d_exc) begin
            state_q <= ST_TRAP;
        end else begin
            state_q <= ST_FLOW;
        end
    end

    // captured result
    logic [XLEN-1:0] npc_q, lval_q;
    logic            taken_q, link_q;
    logic [2:0]      cause_q;
    logic [1:0]      kind_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            npc_q   <= '0;
            lval_q  <= '0;
            taken_q <= 1'b0;
            link_q  <= 1'b0;
            cause_q <= CAUSE_NONE;
            kind_q  <= 2'd0;
        end else if (valid_i) begin
            npc_q   <= d_npc;
            lval_q  <= seq_t;
            taken_q <= d_taken;
            link_q  <= d_link;
            cause_q <= d_cause;
            kind_q  <= d_kind;
        end
    end

    // outputs decoded from the state
    always_comb begin
        next_pc_o   = npc_q;
        link_val_o  = link_q ? lval_q : '0;
        taken_o     = 1'b0;
        link_we_o   = 1'b0;
        ret_kind_o  = 2'd0;
        exc_req_o   = 1'b0;
        exc_cause_o = CAUSE_NONE;
        unique case (state_q)
            ST_IDLE: ;
            ST_FLOW: begin
                taken_o    = taken_q;
                link_we_o  = link_q;
                ret_kind_o = kind_q;
            end
            ST_TRAP: begin
                exc_req_o   = 1'b1;
                exc_cause_o = cause_q;
            end
            default: ;
        endcase
    end

    // checks
    assert_trap_alone_R11: assert property (@(posedge clk) disable iff (rst)
        exc_req_o |-> (!taken_o && !link_we_o));

    assert_trap_pc_R7: assert property (@(posedge clk) disable iff (rst)
        exc_req_o |-> (next_pc_o == ($past(pc_i) & ~XLEN'(3))));

    assert_link_val_R5: assert property (@(posedge clk) disable iff (rst)
        link_we_o |-> (link_val_o == (($past(pc_i) & ~XLEN'(3)) + XLEN'(4))));

    assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(valid_i) |-> (!taken_o && !link_we_o && !exc_req_o));

    assert_aligned_R10: assert property (@(posedge clk) disable iff (rst)
        next_pc_o[1:0] == 2'b00);

    assert_cause_set_R8: assert property (@(posedge clk) disable iff (rst)
        exc_req_o |-> (exc_cause_o != CAUSE_NONE));
endmodule

// File: tb/nxpc_unit_tb.sv
module nxpc_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 30;

    typedef struct packed {
        logic [3:0]  req;
        logic [5:0]  op;
        logic [31:0] pc;
        logic [25:0] imm;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] npc;
        logic        tk;
        logic        lk;
        logic [31:0] lv;
        logic        ex;
        logic [2:0]  cause;
        logic [1:0]  kind;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        // R3 immediate jump forward and backward
        '{4'd3, 6'h38, 32'h1000, 26'h0000010, 32'h0, 32'h0, 32'h1040, 1'b1, 1'b0, 32'h0, 1'b0, 3'd0, 2'd0},
        '{4'd3, 6'h38, 32'h1000, 26'h3FFFFFF, 32'h0, 32'h0, 32'h0FFC, 1'b1, 1'b0, 32'h0, 1'b0, 3'd0, 2'd0},
        // R5 immediate call writes link
        '{4'd5, 6'h3E, 32'h1000, 26'h0000004, 32'h0, 32'h0, 32'h1010, 1'b1, 1'b1, 32'h1004, 1'b0, 3'd0, 2'd0},
        // R4 conditional branches
        '{4'd4, 6'h11, 32'h1000, 26'h0008, 32'h5, 32'h5, 32'h1020, 1'b1, 1'b0, 32'h0, 1'b0, 3'd0, 2'd0},
        '{4'd4, 6'h11, 32'h1000, 26'h0008, 32'h5, 32'h6, 32'h1004, 1'b0, 1'b0, 32'h0, 1'b0, 3'd0, 2'd0},
        '{4'd4, 6'h17, 32'h1000, 26'hFFFE, 32'h5, 32'h6, 32'h0FF8, 1'b1, 1'b0, 32'h0, 1'b0, 3'd0, 2'd0},
        '{4'd4, 6'h17, 32'h1000, 26'hFFFE, 32'h7, 32'h7, 32'h1004, 1'b0, 1'b0, 32'h0, 1'b0, 3'd0, 2'd0},
        '{4'd4, 6'h12, 32'h1000, 26'h0004, 32'hFFFFFFFF, 32'h1, 32'h1004, 1'b0, 1'b0, 32'h0, 1'b0, 3'd0, 2'd0},
        '{4'd4, 6'h15, 32'h1000, 26'h0004, 32'hFFFFFFFF, 32'h1, 32'h1010, 1'b1, 1'b0, 32'h0, 1'b0, 3'd0, 2'd0},
        '{4'd4, 6'h13, 32'h1000, 26'h0010, 32'h3, 32'h3, 32'h1040, 1'b1, 1'b0, 32'h0, 1'b0, 3'd0, 2'd0},
        '{4'd4, 6'h13, 32'h1000, 26'h0010, 32'h80000000, 32'h1, 32'h1004, 1'b0, 1'b0, 32'h0, 1'b0, 3'd0, 2'd0},
        '{4'd4, 6'h14, 32'h1000, 26'h0010, 32'h80000000, 32'h1, 32'h1040, 1'b1, 1'b0, 32'h0, 1'b0, 3'd0, 2'd0},
        '{4'd4, 6'h14, 32'h1000, 26'h0010, 32'h1, 32'h2, 32'h1004, 1'b0, 1'b0, 32'h0, 1'b0, 3'd0, 2'd0},
        '{4'd4, 6'h12, 32'h1000, 26'h0004, 32'h2, 32'h1, 32'h1010, 1'b1, 1'b0, 32'h0, 1'b0, 3'd0, 2'd0},
        '{4'd4, 6'h15, 32'h1000, 26'h0004, 32'h1, 32'h1, 32'h1004, 1'b0, 1'b0, 32'h0, 1'b0, 3'd0, 2'd0},
        // R6 register jumps and return tags
        '{4'd6, 6'h30, 32'h1000, 26'h3A00000, 32'h2003, 32'h0, 32'h2000, 1'b1, 1'b0, 32'h0, 1'b0, 3'd0, 2'd1},
        '{4'd6, 6'h30, 32'h1000, 26'h3C00000, 32'h4000, 32'h0, 32'h4000, 1'b1, 1'b0, 32'h0, 1'b0, 3'd0, 2'd2},
        '{4'd6, 6'h30, 32'h1000, 26'h3E00000, 32'h5001, 32'h0, 32'h5000, 1'b1, 1'b0, 32'h0, 1'b0, 3'd0, 2'd3},
        '{4'd6, 6'h30, 32'h1000, 26'h0A00000, 32'h6000, 32'h0, 32'h6000, 1'b1, 1'b0, 32'h0, 1'b0, 3'd0, 2'd0},
        '{4'd6, 6'h36, 32'h1000, 26'h3A00000, 32'h3000, 32'h0, 32'h3000, 1'b1, 1'b1, 32'h1004, 1'b0, 3'd0, 2'd0},
        // R7 system-call opcode codes
        '{4'd7, 6'h2B, 32'h1000, 26'h0000007, 32'h0, 32'h0, 32'h1000, 1'b0, 1'b0, 32'h0, 1'b1, 3'd2, 2'd0},
        '{4'd7, 6'h2B, 32'h1000, 26'h0000002, 32'h0, 32'h0, 32'h1000, 1'b0, 1'b0, 32'h0, 1'b1, 3'd1, 2'd0},
        '{4'd7, 6'h2B, 32'h1000, 26'h0000003, 32'h0, 32'h0, 32'h1000, 1'b0, 1'b0, 32'h0, 1'b1, 3'd4, 2'd0},
        // R8 divide by zero
        '{4'd8, 6'h23, 32'h1000, 26'h0, 32'h9, 32'h0, 32'h1000, 1'b0, 1'b0, 32'h0, 1'b1, 3'd3, 2'd0},
        '{4'd8, 6'h23, 32'h1000, 26'h0, 32'h9, 32'h4, 32'h1004, 1'b0, 1'b0, 32'h0, 1'b0, 3'd0, 2'd0},
        '{4'd8, 6'h31, 32'h1000, 26'h0, 32'h9, 32'h0, 32'h1000, 1'b0, 1'b0, 32'h0, 1'b1, 3'd3, 2'd0},
        // R9 ordinary opcode
        '{4'd9, 6'h0D, 32'h1000, 26'h0, 32'h0, 32'h0, 32'h1004, 1'b0, 1'b0, 32'h0, 1'b0, 3'd0, 2'd0},
        // R10 low PC bits ignored
        '{4'd10, 6'h0D, 32'h1003, 26'h0, 32'h0, 32'h0, 32'h1004, 1'b0, 1'b0, 32'h0, 1'b0, 3'd0, 2'd0},
        '{4'd10, 6'h38, 32'h2002, 26'h0000001, 32'h0, 32'h0, 32'h2004, 1'b1, 1'b0, 32'h0, 1'b0, 3'd0, 2'd0},
        // R3 call crossing to zero, R5 link
        '{4'd3, 6'h3E, 32'h0010, 26'h3FFFFFC, 32'h0, 32'h0, 32'h0000, 1'b1, 1'b1, 32'h0014, 1'b0, 3'd0, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [31:0] pc_i = '0;
    logic [5:0]  opcode_i = '0;
    logic [25:0] imm_i = '0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic [31:0] next_pc_o, link_val_o;
    logic        taken_o, link_we_o, exc_req_o;
    logic [1:0]  ret_kind_o;
    logic [2:0]  exc_cause_o;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nxpc_unit u_dut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .pc_i(pc_i),
        .opcode_i(opcode_i), .imm_i(imm_i), .opa_i(opa_i), .opb_i(opb_i),
        .next_pc_o(next_pc_o), .taken_o(taken_o), .link_we_o(link_we_o),
        .link_val_o(link_val_o), .ret_kind_o(ret_kind_o),
        .exc_req_o(exc_req_o), .exc_cause_o(exc_cause_o)
    );

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [5:0] op, input logic [31:0] pc,
                         input logic [25:0] imm, input logic [31:0] a,
                         input logic [31:0] b);
        @(negedge clk);
        valid_i  = 1'b1;
        opcode_i = op;
        pc_i     = pc;
        imm_i    = imm;
        opa_i    = a;
        opb_i    = b;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R2 watchdog expired: actual hung expected done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 outputs during reset
        check(1, "next_pc in reset", next_pc_o, 32'h0);
        check(1, "exc in reset", {31'b0, exc_req_o}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        // R1 outputs after reset release, no strobe yet
        check(1, "next_pc after reset", next_pc_o, 32'h0);
        check(1, "taken after reset", {31'b0, taken_o}, 32'h0);
        check(1, "link after reset", {31'b0, link_we_o}, 32'h0);
        check(1, "cause after reset", {29'b0, exc_cause_o}, 32'h0);

        // table walk, back to back strobes (R2 one-cycle latency)
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].op, VECS[i].pc, VECS[i].imm, VECS[i].a, VECS[i].b);
            @(posedge clk);
            #1;
            check(VECS[i].req, $sformatf("v%0d next_pc", i), next_pc_o, VECS[i].npc);
            check(VECS[i].req, $sformatf("v%0d taken", i), {31'b0, taken_o}, {31'b0, VECS[i].tk});
            check(VECS[i].req, $sformatf("v%0d link_we", i), {31'b0, link_we_o}, {31'b0, VECS[i].lk});
            if (VECS[i].lk)
                check(VECS[i].req, $sformatf("v%0d link_val", i), link_val_o, VECS[i].lv);
            // R11 exception request and cause
            check(VECS[i].req, $sformatf("v%0d exc_req", i), {31'b0, exc_req_o}, {31'b0, VECS[i].ex});
            check(VECS[i].req, $sformatf("v%0d cause", i), {29'b0, exc_cause_o}, {29'b0, VECS[i].cause});
            check(VECS[i].req, $sformatf("v%0d ret_kind", i), {30'b0, ret_kind_o}, {30'b0, VECS[i].kind});
        end

        // R2 strobe dropped: flags low, next_pc held at last result
        @(negedge clk);
        valid_i = 1'b0;
        opcode_i = 6'h38;
        imm_i = 26'h0000040;
        @(posedge clk);
        #1;
        check(2, "idle taken", {31'b0, taken_o}, 32'h0);
        check(2, "idle link", {31'b0, link_we_o}, 32'h0);
        check(2, "idle exc", {31'b0, exc_req_o}, 32'h0);
        check(2, "idle next_pc held", next_pc_o, 32'h0);

        // R2 trap then idle returns to quiet
        drive(6'h2B, 32'h0800, 26'h0000007, 32'h0, 32'h0);
        @(posedge clk);
        #1;
        check(7, "trap exc", {31'b0, exc_req_o}, 32'h1);
        @(negedge clk);
        valid_i = 1'b0;
        @(posedge clk);
        #1;
        check(2, "post-trap exc", {31'b0, exc_req_o}, 32'h0);
        check(2, "post-trap next_pc held", next_pc_o, 32'h0800);

        // R1 reset mid-run clears a pending result
        drive(6'h3E, 32'h0100, 26'h0000001, 32'h0, 32'h0);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check(1, "reset taken", {31'b0, taken_o}, 32'h0);
        check(1, "reset next_pc", next_pc_o, 32'h0);
        check(1, "reset link", {31'b0, link_we_o}, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule